// File: doc/BRIEF.md
# Request Tracker Occupancy Monitor

This block watches two request trackers that sit beside a memory path. One is the memory request tracker, which holds requests waiting for data from memory. The other is the coherency tracker. Each tracker reports allocate and retire strobes. Memory tracker allocations also carry a request kind: read, full write, partial write or eviction. The block keeps a count of the outstanding entries in each tracker and guards that count against overflow and underflow.

A performance counter downstream adds the value of `evt_inc` on every clock. An event code and a unit mask together select what `evt_inc` carries. There are two sorts of event. An occupancy event adds the current number of pending entries on every cycle, so the counter accumulates entry-cycles. An allocation event adds one for each accepted allocation that passes the unit-mask filter.

Top module: `req_track_mon`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, both pending counts read 0, `evt_inc` is 0 and both error flags are low.
- R2: An accepted allocate on its own raises that tracker's pending count by one on the next clock edge. An accepted retire on its own lowers it by one.
- R3: An allocate and a retire in the same cycle on a non-empty tracker leave its pending count unchanged. Neither error flag is raised.
- R4: Each tracker holds at most DEPTH entries (32 by default). An allocate on a full tracker with no retire in the same cycle raises that tracker's error flag in that cycle and is ignored, so the count stays at DEPTH. A full tracker that sees an allocate and a retire together stays at DEPTH with no error.
- R5: A retire on an empty tracker raises that tracker's error flag in that cycle and is ignored. If an allocate arrives in the same cycle, the allocate is still accepted and the count becomes 1.
- R6: With code 0x80 and mask 0x01, `evt_inc` equals the memory tracker's pending count in every cycle.
- R7: With code 0x81 and mask 0x01, `evt_inc` is 1 in each cycle that a memory allocation of any kind is accepted, and 0 in every other cycle.
- R8: With code 0x81 and mask 0x20, `evt_inc` is 1 in each cycle that a memory allocation is accepted with a kind of full write (`2'b01`), partial write (`2'b10`) or eviction (`2'b11`). A read (`2'b00`) gives 0.
- R9: With code 0x81 and mask 0x80, `evt_inc` is 1 only for an accepted memory allocation of kind eviction (`2'b11`).
- R10: With code 0x83 and mask 0x01, `evt_inc` equals the coherency tracker's pending count in every cycle.
- R11: With code 0x84 and mask 0x01, `evt_inc` is 1 in each cycle that a coherency allocation is accepted. Memory tracker allocations do not count toward this event.
- R12: Any other pair of code and mask drives `evt_inc` to 0, whatever the trackers do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_alloc | input | 1 | Memory tracker allocate strobe |
| mem_alloc_kind | input | 2 | Kind of the memory allocation: 00 read, 01 full write, 10 partial write, 11 eviction |
| mem_retire | input | 1 | Memory tracker retire strobe |
| coh_alloc | input | 1 | Coherency tracker allocate strobe |
| coh_retire | input | 1 | Coherency tracker retire strobe |
| evt_code | input | 8 | Event code selection |
| evt_umask | input | 8 | Unit mask selection |
| evt_inc | output | CW | Per-cycle increment sent to the counter (CW = clog2(DEPTH+1)) |
| mem_pending | output | CW | Outstanding memory tracker entries |
| coh_pending | output | CW | Outstanding coherency tracker entries |
| mem_err | output | 1 | Memory tracker overflow or underflow attempt in this cycle |
| coh_err | output | 1 | Coherency tracker overflow or underflow attempt in this cycle |

## Verification
The assertions check on every cycle that neither pending count passes DEPTH. They also check that a lone accepted allocate steps the count by exactly one, that a paired allocate and retire holds the count, that ignored overflow and underflow strobes leave it pinned, and that both occupancy selections pass the live pending counts. Some behaviour can only be shown by the bench's scenarios. These are the unit-mask filtering of each request kind, the zero output for unsupported selections, and the full and empty boundaries reached by filling and draining a tracker. The last needs a long, ordered run of strobes with known totals.

// File: rtl/req_track_mon.sv
module req_track_mon #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mem_alloc,
  input  logic [1:0]    mem_alloc_kind,
  input  logic          mem_retire,
  input  logic          coh_alloc,
  input  logic          coh_retire,
  input  logic [7:0]    evt_code,
  input  logic [7:0]    evt_umask,
  output logic [CW-1:0] evt_inc,
  output logic [CW-1:0] mem_pending,
  output logic [CW-1:0] coh_pending,
  output logic          mem_err,
  output logic          coh_err
);

  localparam logic [1:0] KIND_READ  = 2'b00;
  localparam logic [1:0] KIND_EVICT = 2'b11;
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic mem_take, mem_free, coh_take, coh_free;

  // accept an allocate unless full with nothing leaving; accept a retire unless empty
  assign mem_take = mem_alloc  && ((mem_pending != CAP) || mem_retire);
  assign mem_free = mem_retire && (mem_pending != '0);
  assign coh_take = coh_alloc  && ((coh_pending != CAP) || coh_retire);
  assign coh_free = coh_retire && (coh_pending != '0);

  assign mem_err = (mem_alloc && !mem_take) || (mem_retire && !mem_free);
  assign coh_err = (coh_alloc && !coh_take) || (coh_retire && !coh_free);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_pending <= '0;
      coh_pending <= '0;
    end else begin
      mem_pending <= mem_pending + CW'(mem_take) - CW'(mem_free);
      coh_pending <= coh_pending + CW'(coh_take) - CW'(coh_free);
    end
  end

  always_comb begin
    evt_inc = '0;
    case ({evt_code, evt_umask})
      16'h8001: evt_inc = mem_pending;
      16'h8101: evt_inc = CW'(mem_take);
      16'h8120: evt_inc = CW'(mem_take && (mem_alloc_kind != KIND_READ));
      16'h8180: evt_inc = CW'(mem_take && (mem_alloc_kind == KIND_EVICT));
      16'h8301: evt_inc = coh_pending;
      16'h8401: evt_inc = CW'(coh_take);
      default:  evt_inc = '0;
    endcase
  end

  a_r4_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_pending <= CAP) && (coh_pending <= CAP));

  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_alloc && !mem_retire && !mem_err) |=> (mem_pending == $past(mem_pending) + CW'(1)));

  a_r3_pair_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_alloc && mem_retire && (mem_pending != '0)) |=> $stable(mem_pending));

  a_r4_full_alloc_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_alloc && !mem_retire && (mem_pending == CAP)) |=> (mem_pending == CAP));

  a_r5_empty_retire_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (coh_retire && !coh_alloc && (coh_pending == '0)) |=> (coh_pending == '0));

  a_r6_mem_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_code == 8'h80 && evt_umask == 8'h01) |-> (evt_inc == mem_pending));

  a_r10_coh_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_code == 8'h83 && evt_umask == 8'h01) |-> (evt_inc == coh_pending));

endmodule

// File: tb/req_track_mon_bench.sv
module req_track_mon_bench;
  localparam int DEPTH = 32;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_alloc = 0, mem_retire = 0, coh_alloc = 0, coh_retire = 0;
  logic [1:0] mem_alloc_kind = 2'b00;
  logic [7:0] evt_code = 8'h00, evt_umask = 8'h00;
  logic [CW-1:0] evt_inc, mem_pending, coh_pending;
  logic mem_err, coh_err;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  req_track_mon #(.DEPTH(DEPTH)) u_req_track_mon (
    .clk(clk), .rst_n(rst_n),
    .mem_alloc(mem_alloc), .mem_alloc_kind(mem_alloc_kind), .mem_retire(mem_retire),
    .coh_alloc(coh_alloc), .coh_retire(coh_retire),
    .evt_code(evt_code), .evt_umask(evt_umask),
    .evt_inc(evt_inc), .mem_pending(mem_pending), .coh_pending(coh_pending),
    .mem_err(mem_err), .coh_err(coh_err)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL R0 watchdog expired: actual %0d cycles expected < 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic chk(string tag, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic drive(bit a, logic [1:0] k, bit r, bit ca, bit cr);
    @(negedge clk);
    mem_alloc = a; mem_alloc_kind = k; mem_retire = r;
    coh_alloc = ca; coh_retire = cr;
    #1;
  endtask

  task automatic idle();
    drive(0, 2'b00, 0, 0, 0);
  endtask

  task automatic sel(logic [7:0] c, logic [7:0] m);
    evt_code = c; evt_umask = m;
  endtask

  task automatic mem_retire_n(int n);
    for (int i = 0; i < n; i++) drive(0, 2'b00, 1, 0, 0);
  endtask

  task automatic t_reset();
    sel(8'h80, 8'h01);
    repeat (3) @(negedge clk);
    #1;
    chk("R1 pending during reset", mem_pending, 0);
    chk("R1 err during reset", mem_err, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 mem_pending after reset", mem_pending, 0);
    chk("R1 coh_pending after reset", coh_pending, 0);
    chk("R1 evt_inc after reset", evt_inc, 0);
    chk("R1 errors after reset", {mem_err, coh_err}, 0);
  endtask

  task automatic t_mem_events();
    sel(8'h81, 8'h01);
    drive(1, 2'b00, 0, 0, 0);
    chk("R7 read alloc counted", evt_inc, 1);
    idle();
    chk("R2 pending after one alloc", mem_pending, 1);
    chk("R7 no alloc gives zero", evt_inc, 0);
    sel(8'h81, 8'h20);
    drive(1, 2'b00, 0, 0, 0);
    chk("R8 read filtered out", evt_inc, 0);
    drive(1, 2'b01, 0, 0, 0);
    chk("R8 full write counted", evt_inc, 1);
    drive(1, 2'b10, 0, 0, 0);
    chk("R8 partial write counted", evt_inc, 1);
    drive(1, 2'b11, 0, 0, 0);
    chk("R8 eviction counted", evt_inc, 1);
    sel(8'h81, 8'h80);
    drive(1, 2'b10, 0, 0, 0);
    chk("R9 partial write filtered out", evt_inc, 0);
    drive(1, 2'b11, 0, 0, 0);
    chk("R9 eviction counted", evt_inc, 1);
    sel(8'h80, 8'h01);
    idle();
    chk("R2 pending after seven allocs", mem_pending, 7);
    chk("R6 occupancy equals pending", evt_inc, 7);
    drive(0, 2'b00, 1, 0, 0);
    chk("R6 occupancy before retire lands", evt_inc, 7);
    idle();
    chk("R2 retire lowers pending", mem_pending, 6);
    chk("R6 occupancy follows retire", evt_inc, 6);
    mem_retire_n(6);
    idle();
    chk("R2 drained to zero", mem_pending, 0);
    chk("R6 occupancy zero when empty", evt_inc, 0);
  endtask

  task automatic t_pair();
    for (int i = 0; i < 3; i++) drive(1, 2'b01, 0, 0, 0);
    drive(1, 2'b00, 1, 0, 0);
    chk("R3 no error on paired strobes", mem_err, 0);
    idle();
    chk("R3 paired strobes hold count", mem_pending, 3);
    mem_retire_n(3);
    idle();
    chk("R3 drained", mem_pending, 0);
  endtask

  task automatic t_underflow();
    drive(0, 2'b00, 1, 0, 0);
    chk("R5 retire on empty flags error", mem_err, 1);
    idle();
    chk("R5 retire on empty ignored", mem_pending, 0);
    chk("R5 error clears", mem_err, 0);
    drive(1, 2'b00, 1, 0, 0);
    chk("R5 empty pair flags error", mem_err, 1);
    idle();
    chk("R5 alloc kept on empty pair", mem_pending, 1);
    mem_retire_n(1);
    idle();
  endtask

  task automatic t_overflow();
    for (int i = 0; i < DEPTH; i++) drive(1, 2'b00, 0, 0, 0);
    idle();
    chk("R4 filled to capacity", mem_pending, DEPTH);
    chk("R4 no error at capacity", mem_err, 0);
    drive(1, 2'b00, 0, 0, 0);
    chk("R4 alloc on full flags error", mem_err, 1);
    idle();
    chk("R4 alloc on full ignored", mem_pending, DEPTH);
    drive(1, 2'b00, 1, 0, 0);
    chk("R4 full pair no error", mem_err, 0);
    idle();
    chk("R4 full pair holds capacity", mem_pending, DEPTH);
    mem_retire_n(DEPTH);
    idle();
    chk("R4 drained from full", mem_pending, 0);
  endtask

  task automatic t_coh();
    sel(8'h84, 8'h01);
    drive(0, 2'b00, 0, 1, 0);
    chk("R11 coherency alloc counted", evt_inc, 1);
    drive(1, 2'b11, 0, 0, 0);
    chk("R11 memory alloc not counted", evt_inc, 0);
    drive(0, 2'b00, 0, 1, 0);
    sel(8'h83, 8'h01);
    idle();
    chk("R10 coherency occupancy", evt_inc, 2);
    chk("R2 coherency pending", coh_pending, 2);
    chk("R2 memory pending separate", mem_pending, 1);
    drive(0, 2'b00, 1, 0, 1);
    drive(0, 2'b00, 0, 0, 1);
    idle();
    chk("R10 occupancy back to zero", evt_inc, 0);
    drive(0, 2'b00, 0, 0, 1);
    chk("R5 coherency retire on empty flags error", coh_err, 1);
    idle();
    chk("R5 coherency retire on empty ignored", coh_pending, 0);
  endtask

  task automatic t_unsupported();
    drive(1, 2'b00, 0, 1, 0);
    drive(1, 2'b11, 0, 1, 0);
    sel(8'h80, 8'h02);
    idle();
    chk("R12 bad mask on occupancy", evt_inc, 0);
    sel(8'h82, 8'h01);
    idle();
    chk("R12 unused code", evt_inc, 0);
    sel(8'h81, 8'h40);
    drive(1, 2'b11, 0, 0, 0);
    chk("R12 bad mask on alloc event", evt_inc, 0);
    sel(8'h85, 8'h01);
    drive(1, 2'b01, 0, 1, 0);
    chk("R12 unused code with allocs", evt_inc, 0);
    sel(8'h80, 8'h01);
    idle();
    chk("R6 occupancy after unsupported run", evt_inc, 4);
  endtask

  initial begin
    t_reset();
    t_mem_events();
    t_pair();
    t_underflow();
    t_overflow();
    t_coh();
    t_unsupported();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule